// File: doc/BRIEF.md
# Burst-of-Two Quad-Data-Rate SRAM Controller

This block is the host-side sequencer for a static RAM with separate read and write data ports. The RAM moves a fixed pair of beats on every access, and both of its clock phases carry meaning. User logic issues reads and writes on two independent valid/ready channels. A write request carries one address, two data words and one byte-enable mask for each word. A read request carries an address and a user tag. The block can accept one read and one write in every clock cycle. Both are placed on the memory pins in the following cycle, with no turnaround gap between them.

The pin side is given as single-data-rate lanes, one lane for each clock phase. The rising-phase address lane carries the read address, which goes with the active-low read strobe. The falling-phase address lane carries the write address of the same cycle, which goes with the active-low write strobe. Both write beats and their active-low byte strobes are presented in the cycle of the write command. Beat 0 belongs to the rising phase and beat 1 to the falling phase.

The SRAM's 1.5-cycle read return is realigned by a PHY that is outside this block. The PHY presents both returned beats together on two capture lanes, a fixed number of cycles after the command. A shift pipeline tracks each outstanding read and its tag. The returned pair is therefore delivered in issue order, with a single-cycle valid pulse.

Top module: `qdr_b2_ctrl`

## Requirements
- R1: While reset is asserted, and on the first clock after reset is released, `mem_rd_n`, `mem_wr_n` and every bit of `mem_bw_n0`/`mem_bw_n1` are 1 and `rsp_valid` is 0. The ready outputs are 0 during reset and become 1 on the first edge at which reset is sampled low.
- R2: A read accepted at a rising edge (`rd_valid` and `rd_ready` both 1) drives `mem_rd_n` low for the next cycle only, with `mem_addr_rise` equal to the accepted address.
- R3: A write accepted at a rising edge drives `mem_wr_n` low for the next cycle only. In that cycle `mem_addr_fall` holds the write address, `mem_d0` holds the first word and `mem_d1` holds the second.
- R4: Byte lane i covers data bits [i*BYTE_W +: BYTE_W]. In a write command cycle, bit i of `mem_bw_n0` equals the inverse of bit i of `wr_be0`, and bit i of `mem_bw_n1` equals the inverse of bit i of `wr_be1`.
- R5: In a cycle with no accepted request of a kind, the strobe for that kind stays high, all byte strobes are high when no write is issued, and each address lane keeps its last value.
- R6: One read and one write accepted at the same edge are both issued in the following cycle. Requests of either kind may be accepted on every consecutive edge.
- R7: For a read issued on the pins in cycle c, the values on `mem_q0` and `mem_q1` at the end of cycle c+RD_LAT are returned on `rsp_data0` and `rsp_data1` with `rsp_valid` high in cycle c+RD_LAT+1.
- R8: Responses come back in issue order, and each response carries the `rd_id` of its request on `rsp_id`.
- R9: `rsp_valid` is high for exactly one cycle per accepted read and never high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (K domain) |
| rst | input | 1 | Synchronous active-high reset |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read channel ready |
| rd_addr | input | ADDR_W | Read burst address |
| rd_id | input | ID_W | Tag returned with the response |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write channel ready |
| wr_addr | input | ADDR_W | Write burst address |
| wr_data0 | input | DATA_W | First write word |
| wr_data1 | input | DATA_W | Second write word |
| wr_be0 | input | DATA_W/BYTE_W | Byte enables for the first word, active high |
| wr_be1 | input | DATA_W/BYTE_W | Byte enables for the second word, active high |
| rsp_valid | output | 1 | Read response pulse |
| rsp_id | output | ID_W | Tag of the returned read |
| rsp_data0 | output | DATA_W | First returned word |
| rsp_data1 | output | DATA_W | Second returned word |
| mem_addr_rise | output | ADDR_W | Address lane for the rising phase (read) |
| mem_addr_fall | output | ADDR_W | Address lane for the falling phase (write) |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |
| mem_d0 | output | DATA_W | Write beat on the rising phase |
| mem_d1 | output | DATA_W | Write beat on the falling phase |
| mem_bw_n0 | output | DATA_W/BYTE_W | Byte strobes for beat 0, active low |
| mem_bw_n1 | output | DATA_W/BYTE_W | Byte strobes for beat 1, active low |
| mem_q0 | input | DATA_W | Returned beat 0 from the PHY |
| mem_q1 | input | DATA_W | Returned beat 1 from the PHY |

## Verification
Every pin-side effect of a request is due one cycle after the edge that accepts it. A read response is due RD_LAT+1 cycles after the read's command cycle, and the model of the memory drives the returned beats during cycle c+RD_LAT. The bench works out these due cycles from a cycle counter and a queue of pending expectations that it keeps itself. It compares every output at the falling edge, half a cycle after the registers update. In every other cycle it checks that no response appears.

// File: rtl/qdr_b2_pkg.sv
package qdr_b2_pkg;

  // fixed burst: two beats per access, no length setting
  localparam int QDR_BEATS = 2;

  function automatic int lane_count(input int data_w, input int lane_w);
    return data_w / lane_w;
  endfunction

endpackage

// File: rtl/qdr_b2_cmd.sv
module qdr_b2_cmd
  import qdr_b2_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 36,
  parameter int LANES  = 4
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                rd_fire_i,
  input  logic [ADDR_W-1:0]                   rd_addr_i,
  input  logic                                wr_fire_i,
  input  logic [ADDR_W-1:0]                   wr_addr_i,
  input  logic [QDR_BEATS-1:0][DATA_W-1:0]    wr_data_i,
  input  logic [QDR_BEATS-1:0][LANES-1:0]     wr_be_i,
  output logic                                mem_rd_n_o,
  output logic                                mem_wr_n_o,
  output logic [ADDR_W-1:0]                   mem_addr_rise_o,
  output logic [ADDR_W-1:0]                   mem_addr_fall_o,
  output logic [QDR_BEATS-1:0][DATA_W-1:0]    mem_d_o,
  output logic [QDR_BEATS-1:0][LANES-1:0]     mem_bw_n_o
);

  // read phase: strobe and address for the rising K edge
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_rd_n_o      <= 1'b1;
      mem_addr_rise_o <= '0;
    end else begin
      mem_rd_n_o <= !rd_fire_i;
      if (rd_fire_i) mem_addr_rise_o <= rd_addr_i;
    end
  end

  // write phase: strobe and address for the falling (K#) edge
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_wr_n_o      <= 1'b1;
      mem_addr_fall_o <= '0;
    end else begin
      mem_wr_n_o <= !wr_fire_i;
      if (wr_fire_i) mem_addr_fall_o <= wr_addr_i;
    end
  end

  // both beats launched in the command cycle; strobes per beat and lane
  for (genvar b = 0; b < QDR_BEATS; b++) begin : g_beat
    always_ff @(posedge clk) begin
      if (rst)            mem_d_o[b] <= '0;
      else if (wr_fire_i) mem_d_o[b] <= wr_data_i[b];
    end
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_ff @(posedge clk) begin
        if (rst) mem_bw_n_o[b][l] <= 1'b1;
        else     mem_bw_n_o[b][l] <= !(wr_fire_i && wr_be_i[b][l]);
      end
    end
  end

  // R2
  rd_addr_chk: assert property (@(posedge clk) disable iff (rst)
    rd_fire_i |=> (!mem_rd_n_o && mem_addr_rise_o == $past(rd_addr_i)));

  // R3
  wr_addr_chk: assert property (@(posedge clk) disable iff (rst)
    wr_fire_i |=> (!mem_wr_n_o && mem_addr_fall_o == $past(wr_addr_i)));

  // R5
  idle_mask_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr_n_o |-> (&mem_bw_n_o));

  // R5
  idle_addr_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_fire_i |=> $stable(mem_addr_rise_o));

endmodule

// File: rtl/qdr_b2_rdtrack.sv
module qdr_b2_rdtrack #(
  parameter int ID_W   = 4,
  parameter int RD_LAT = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            issue_i,
  input  logic [ID_W-1:0] issue_id_i,
  output logic            ret_valid_o,
  output logic [ID_W-1:0] ret_id_o
);

  localparam int STAGES = RD_LAT + 1;

  logic [STAGES-1:0] vld_q;
  logic [ID_W-1:0]   id_q [STAGES];

  // stage 0 is loaded in step with the read strobe register
  always_ff @(posedge clk) begin
    if (rst) vld_q[0] <= 1'b0;
    else     vld_q[0] <= issue_i;
    id_q[0] <= issue_id_i;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) vld_q[k] <= 1'b0;
      else     vld_q[k] <= vld_q[k-1];
      id_q[k] <= id_q[k-1];
    end
  end

  assign ret_valid_o = vld_q[STAGES-1];
  assign ret_id_o    = id_q[STAGES-1];

endmodule

// File: rtl/qdr_b2_capture.sv
module qdr_b2_capture #(
  parameter int DATA_W = 36,
  parameter int ID_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ret_valid_i,
  input  logic [ID_W-1:0]   ret_id_i,
  input  logic [DATA_W-1:0] q0_i,
  input  logic [DATA_W-1:0] q1_i,
  output logic              rsp_valid_o,
  output logic [ID_W-1:0]   rsp_id_o,
  output logic [DATA_W-1:0] rsp_d0_o,
  output logic [DATA_W-1:0] rsp_d1_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_o <= 1'b0;
      rsp_id_o    <= '0;
      rsp_d0_o    <= '0;
      rsp_d1_o    <= '0;
    end else begin
      rsp_valid_o <= ret_valid_i;
      if (ret_valid_i) begin
        rsp_id_o <= ret_id_i;
        rsp_d0_o <= q0_i;
        rsp_d1_o <= q1_i;
      end
    end
  end

  // R7
  beat_capture_chk: assert property (@(posedge clk) disable iff (rst)
    ret_valid_i |=> (rsp_valid_o && rsp_d0_o == $past(q0_i) && rsp_d1_o == $past(q1_i)));

endmodule

// File: rtl/qdr_b2_ctrl.sv
module qdr_b2_ctrl
  import qdr_b2_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 36,
  parameter int BYTE_W = 9,
  parameter int ID_W   = 4,
  parameter int RD_LAT = 2
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic                                     rd_valid,
  output logic                                     rd_ready,
  input  logic [ADDR_W-1:0]                        rd_addr,
  input  logic [ID_W-1:0]                          rd_id,
  input  logic                                     wr_valid,
  output logic                                     wr_ready,
  input  logic [ADDR_W-1:0]                        wr_addr,
  input  logic [DATA_W-1:0]                        wr_data0,
  input  logic [DATA_W-1:0]                        wr_data1,
  input  logic [lane_count(DATA_W, BYTE_W)-1:0]    wr_be0,
  input  logic [lane_count(DATA_W, BYTE_W)-1:0]    wr_be1,
  output logic                                     rsp_valid,
  output logic [ID_W-1:0]                          rsp_id,
  output logic [DATA_W-1:0]                        rsp_data0,
  output logic [DATA_W-1:0]                        rsp_data1,
  output logic [ADDR_W-1:0]                        mem_addr_rise,
  output logic [ADDR_W-1:0]                        mem_addr_fall,
  output logic                                     mem_rd_n,
  output logic                                     mem_wr_n,
  output logic [DATA_W-1:0]                        mem_d0,
  output logic [DATA_W-1:0]                        mem_d1,
  output logic [lane_count(DATA_W, BYTE_W)-1:0]    mem_bw_n0,
  output logic [lane_count(DATA_W, BYTE_W)-1:0]    mem_bw_n1,
  input  logic [DATA_W-1:0]                        mem_q0,
  input  logic [DATA_W-1:0]                        mem_q1
);

  localparam int LANES = lane_count(DATA_W, BYTE_W);

  logic ready_q;
  logic rd_fire, wr_fire;
  logic trk_ret_valid;
  logic [ID_W-1:0] trk_ret_id;
  logic [QDR_BEATS-1:0][DATA_W-1:0] wdata, mdata;
  logic [QDR_BEATS-1:0][LANES-1:0]  wbe, mbw_n;

  // no back-pressure: one read and one write per cycle always fit
  always_ff @(posedge clk) begin
    if (rst) ready_q <= 1'b0;
    else     ready_q <= 1'b1;
  end

  assign rd_ready = ready_q;
  assign wr_ready = ready_q;
  assign rd_fire  = rd_valid && ready_q;
  assign wr_fire  = wr_valid && ready_q;

  assign wdata = {wr_data1, wr_data0};
  assign wbe   = {wr_be1, wr_be0};

  qdr_b2_cmd #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LANES  (LANES)
  ) u_cmd (
    .clk             (clk),
    .rst             (rst),
    .rd_fire_i       (rd_fire),
    .rd_addr_i       (rd_addr),
    .wr_fire_i       (wr_fire),
    .wr_addr_i       (wr_addr),
    .wr_data_i       (wdata),
    .wr_be_i         (wbe),
    .mem_rd_n_o      (mem_rd_n),
    .mem_wr_n_o      (mem_wr_n),
    .mem_addr_rise_o (mem_addr_rise),
    .mem_addr_fall_o (mem_addr_fall),
    .mem_d_o         (mdata),
    .mem_bw_n_o      (mbw_n)
  );

  assign mem_d0    = mdata[0];
  assign mem_d1    = mdata[1];
  assign mem_bw_n0 = mbw_n[0];
  assign mem_bw_n1 = mbw_n[1];

  qdr_b2_rdtrack #(
    .ID_W   (ID_W),
    .RD_LAT (RD_LAT)
  ) u_track (
    .clk         (clk),
    .rst         (rst),
    .issue_i     (rd_fire),
    .issue_id_i  (rd_id),
    .ret_valid_o (trk_ret_valid),
    .ret_id_o    (trk_ret_id)
  );

  qdr_b2_capture #(
    .DATA_W (DATA_W),
    .ID_W   (ID_W)
  ) u_capture (
    .clk         (clk),
    .rst         (rst),
    .ret_valid_i (trk_ret_valid),
    .ret_id_i    (trk_ret_id),
    .q0_i        (mem_q0),
    .q1_i        (mem_q1),
    .rsp_valid_o (rsp_valid),
    .rsp_id_o    (rsp_id),
    .rsp_d0_o    (rsp_data0),
    .rsp_d1_o    (rsp_data1)
  );

  // R6
  dual_issue_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_fire && wr_fire) |=> (!mem_rd_n && !mem_wr_n));

  // R8
  rsp_tag_chk: assert property (@(posedge clk) disable iff (rst)
    trk_ret_valid |=> (rsp_id == $past(trk_ret_id)));

endmodule

// File: tb/test_qdr_b2_ctrl.sv
module test_qdr_b2_ctrl;

  localparam int AW  = 20;
  localparam int DW  = 36;
  localparam int BW  = 9;
  localparam int IW  = 4;
  localparam int LAT = 2;
  localparam int LN  = DW / BW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst;
  logic          rd_valid, rd_ready, wr_valid, wr_ready;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [IW-1:0] rd_id;
  logic [DW-1:0] wr_data0, wr_data1;
  logic [LN-1:0] wr_be0, wr_be1;
  logic          rsp_valid;
  logic [IW-1:0] rsp_id;
  logic [DW-1:0] rsp_data0, rsp_data1;
  logic [AW-1:0] mem_addr_rise, mem_addr_fall;
  logic          mem_rd_n, mem_wr_n;
  logic [DW-1:0] mem_d0, mem_d1, mem_q0, mem_q1;
  logic [LN-1:0] mem_bw_n0, mem_bw_n1;

  qdr_b2_ctrl #(.ADDR_W(AW), .DATA_W(DW), .BYTE_W(BW), .ID_W(IW), .RD_LAT(LAT)) i_qdr_b2_ctrl (
    .clk(clk), .rst(rst),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_id(rd_id),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data0(wr_data0), .wr_data1(wr_data1), .wr_be0(wr_be0), .wr_be1(wr_be1),
    .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_data0(rsp_data0), .rsp_data1(rsp_data1),
    .mem_addr_rise(mem_addr_rise), .mem_addr_fall(mem_addr_fall),
    .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .mem_d0(mem_d0), .mem_d1(mem_d1),
    .mem_bw_n0(mem_bw_n0), .mem_bw_n1(mem_bw_n1), .mem_q0(mem_q0), .mem_q1(mem_q1)
  );

  typedef struct packed {
    logic [31:0]   due;
    logic [IW-1:0] id;
    logic [DW-1:0] d0;
    logic [DW-1:0] d1;
  } pend_t;

  pend_t         exq[$];
  pend_t         memq[$];
  logic [DW-1:0] refm[int];
  logic [DW-1:0] sram[int];

  int cyc = 0;
  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  // expected pin state for the current cycle
  logic          e_ready, e_rd_n, e_wr_n;
  logic [AW-1:0] e_ar, e_af;
  logic [DW-1:0] e_d0, e_d1;
  logic [LN-1:0] e_bw0, e_bw1;
  logic          racc, wacc;
  logic [DW-1:0] v0, v1;
  pend_t         pe;

  function automatic logic [DW-1:0] ref_get(int k);
    if (refm.exists(k)) return refm[k];
    return '0;
  endfunction

  function automatic logic [DW-1:0] sram_get(int k);
    if (sram.exists(k)) return sram[k];
    return '0;
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // behavioural reference: acceptance and expected pins per edge
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rst) begin
      e_ready = 1'b0; e_rd_n = 1'b1; e_wr_n = 1'b1;
      e_ar = '0; e_af = '0; e_d0 = '0; e_d1 = '0;
      e_bw0 = '1; e_bw1 = '1;
      exq.delete();
    end else begin
      racc = rd_valid && e_ready;
      wacc = wr_valid && e_ready;
      e_rd_n = !racc;
      if (racc) begin
        e_ar  = rd_addr;
        pe.due = 32'(cyc + LAT + 1);
        pe.id  = rd_id;
        pe.d0  = ref_get(int'(rd_addr) * 2);
        pe.d1  = ref_get(int'(rd_addr) * 2 + 1);
        exq.push_back(pe);
      end
      e_wr_n = !wacc;
      if (wacc) begin
        e_af = wr_addr; e_d0 = wr_data0; e_d1 = wr_data1;
        e_bw0 = ~wr_be0; e_bw1 = ~wr_be1;
        v0 = ref_get(int'(wr_addr) * 2);
        v1 = ref_get(int'(wr_addr) * 2 + 1);
        for (int l = 0; l < LN; l++) begin
          if (wr_be0[l]) v0[l*BW +: BW] = wr_data0[l*BW +: BW];
          if (wr_be1[l]) v1[l*BW +: BW] = wr_data1[l*BW +: BW];
        end
        refm[int'(wr_addr) * 2]     = v0;
        refm[int'(wr_addr) * 2 + 1] = v1;
      end else begin
        e_bw0 = '1; e_bw1 = '1;
      end
      e_ready = 1'b1;
    end
  end

  // mid-cycle compare plus the memory model
  always @(negedge clk) begin
    if (cyc > 0) begin
      chk("R1", "rd_ready", 64'(rd_ready), 64'(e_ready));
      chk("R1", "wr_ready", 64'(wr_ready), 64'(e_ready));
      chk(rst ? "R1" : "R2", "mem_rd_n", 64'(mem_rd_n), 64'(e_rd_n));
      chk(rst ? "R1" : "R3", "mem_wr_n", 64'(mem_wr_n), 64'(e_wr_n));
      chk(e_rd_n ? "R5" : "R2", "mem_addr_rise", 64'(mem_addr_rise), 64'(e_ar));
      chk(e_wr_n ? "R5" : "R3", "mem_addr_fall", 64'(mem_addr_fall), 64'(e_af));
      chk(e_wr_n ? "R5" : "R4", "mem_bw_n0", 64'(mem_bw_n0), 64'(e_bw0));
      chk(e_wr_n ? "R5" : "R4", "mem_bw_n1", 64'(mem_bw_n1), 64'(e_bw1));
      if (!e_wr_n) begin
        chk("R3", "mem_d0", 64'(mem_d0), 64'(e_d0));
        chk("R3", "mem_d1", 64'(mem_d1), 64'(e_d1));
      end
      if (!e_rd_n && !e_wr_n)
        chk("R6", "dual issue strobes", 64'({mem_rd_n, mem_wr_n}), 64'(0));
      if (exq.size() > 0 && exq[0].due == 32'(cyc)) begin
        chk("R7", "rsp_valid", 64'(rsp_valid), 64'(1));
        chk("R8", "rsp_id", 64'(rsp_id), 64'(exq[0].id));
        chk("R7", "rsp_data0", 64'(rsp_data0), 64'(exq[0].d0));
        chk("R7", "rsp_data1", 64'(rsp_data1), 64'(exq[0].d1));
        void'(exq.pop_front());
      end else begin
        chk(rst ? "R1" : "R9", "rsp_valid idle", 64'(rsp_valid), 64'(0));
      end
    end
    // SRAM model at pin level: read sampled before this cycle's write
    if (!rst && mem_rd_n === 1'b0) begin
      pe.due = 32'(cyc + LAT);
      pe.id  = '0;
      pe.d0  = sram_get(int'(mem_addr_rise) * 2);
      pe.d1  = sram_get(int'(mem_addr_rise) * 2 + 1);
      memq.push_back(pe);
    end
    if (!rst && mem_wr_n === 1'b0) begin
      v0 = sram_get(int'(mem_addr_fall) * 2);
      v1 = sram_get(int'(mem_addr_fall) * 2 + 1);
      for (int l = 0; l < LN; l++) begin
        if (!mem_bw_n0[l]) v0[l*BW +: BW] = mem_d0[l*BW +: BW];
        if (!mem_bw_n1[l]) v1[l*BW +: BW] = mem_d1[l*BW +: BW];
      end
      sram[int'(mem_addr_fall) * 2]     = v0;
      sram[int'(mem_addr_fall) * 2 + 1] = v1;
    end
    if (memq.size() > 0 && memq[0].due == 32'(cyc)) begin
      mem_q0 = memq[0].d0;
      mem_q1 = memq[0].d1;
      void'(memq.pop_front());
    end else begin
      mem_q0 = 36'h5_A5A5_A5A5 ^ DW'(cyc);
      mem_q1 = 36'hA_5A5A_5A5A ^ DW'(cyc);
    end
  end

  task automatic drive(input logic rv, input logic [AW-1:0] ra, input logic [IW-1:0] rid,
                       input logic wv, input logic [AW-1:0] wa,
                       input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                       input logic [LN-1:0] b0, input logic [LN-1:0] b1);
    @(negedge clk);
    rd_valid = rv; rd_addr = ra; rd_id = rid;
    wr_valid = wv; wr_addr = wa; wr_data0 = d0; wr_data1 = d1;
    wr_be0 = b0; wr_be1 = b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, '0, '0, 1'b0, '0, '0, '0, '0, '0);
  endtask

  function automatic logic [DW-1:0] pat(input int i, input int beat);
    return DW'(i * 36'h0_0101_0203) ^ (beat != 0 ? 36'hF_0F0F_0F0F : 36'h3_C3C3_3C3C);
  endfunction

  initial begin
    rst = 1'b1;
    rd_valid = 0; rd_addr = '0; rd_id = '0;
    wr_valid = 0; wr_addr = '0; wr_data0 = '0; wr_data1 = '0; wr_be0 = '0; wr_be1 = '0;
    mem_q0 = '0; mem_q1 = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R3 R4: full-mask writes on consecutive cycles
    for (int i = 0; i < 8; i++)
      drive(1'b0, '0, '0, 1'b1, AW'(i), pat(i, 0), pat(i, 1), '1, '1);
    idle(2);
    // R2 R7 R8: back-to-back reads with distinct tags
    for (int i = 0; i < 8; i++)
      drive(1'b1, AW'(i), IW'(i), 1'b0, '0, '0, '0, '0, '0);
    idle(3);
    // R4: partial byte masks per beat and lane
    drive(1'b0, '0, '0, 1'b1, AW'(3), 36'h1_2345_6789, 36'h9_8765_4321, 4'b0101, 4'b1010);
    drive(1'b0, '0, '0, 1'b1, AW'(5), 36'hF_FFFF_FFFF, 36'h0_0000_0000, 4'b0000, 4'b1001);
    idle(1);
    // R6: read and write accepted at every edge
    for (int i = 0; i < 8; i++)
      drive(1'b1, AW'(i), IW'(8 + i), 1'b1, AW'(16 + i), pat(40 + i, 0), pat(40 + i, 1), '1, 4'b0110);
    idle(4);
    // R5 R9: sparse reads separated by idle cycles
    for (int i = 0; i < 8; i++) begin
      drive(1'b1, AW'(16 + i), IW'(i + 3), 1'b0, '0, '0, '0, '0, '0);
      idle(i % 3);
    end
    drive(1'b1, AW'(3), 4'hE, 1'b0, '0, '0, '0, '0, '0);
    drive(1'b1, AW'(5), 4'hF, 1'b0, '0, '0, '0, '0, '0);
    idle(12);
    chk("R9", "responses outstanding at end", 64'(exq.size()), 64'(0));
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL R9 watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule